// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a two-wire serial bus placed in front of a byte-wide memory with a 15-bit word address. It samples the bus clock and data lines with the system clock and finds start and stop conditions. It compares the device address byte against a fixed type code and three strap inputs, then takes in a two-byte word address and data bytes. It acknowledges every accepted byte and serves data back through an output enable that only ever pulls the data line low.

A word-address counter persists from one transaction to the next. Writes store each acknowledged byte at once and step the counter inside its 64-byte page. Reads step the counter across the whole 32K space. A random read is a write of the word address only, followed by a repeated start and a read address. The memory model holds 2^RAM_AW bytes (1024 by default), indexed by the low counter bits. Deeper arrays only need a larger parameter.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the block does not drive the data line (sda_oe = 0) and waits for a start.
- R2: A start (data falls while clock is high) always restarts device-address reception. A stop (data rises while clock is high) returns the block to idle, and bytes clocked while idle get no acknowledge and change nothing.
- R3: The device address byte is sent MSB first as 1,0,1,0, then strap_i[2:0], then a direction bit (1 = read, 0 = write). On a match the block pulls the data line low for the ninth clock. On a mismatch it gives no acknowledge to that byte or to any later byte until the next start.
- R4: In a write, the two bytes after the device address form the word address, high byte first, and each is acknowledged. Bit 7 of the high byte is ignored.
- R5: Each data byte of a write is acknowledged and stored at the counter, and the counter then advances. Several bytes land at consecutive addresses.
- R6: During writes only the low 6 counter bits advance, so the byte after offset 63 of a page goes to offset 0 of the same page.
- R7: A read with no word address returns the byte at the counter, which holds the last accessed address plus one across transactions.
- R8: A random read (word address write, repeated start, read address) returns the byte at the loaded address.
- R9: In a read, the counter advances after every byte across the full 15-bit space, wrapping from 0x7FFF to 0x0000.
- R10: When the master leaves the ninth bit of a read byte high, the block releases the line and stays silent until the next start.
- R11: A start inside a data byte discards that partial byte and begins a new device address.
- R12: The block changes its data output only after a falling clock edge. It never starts driving while the clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Board strap bits compared with the device address |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions assume a bus master that keeps each clock phase at least several system clocks long. They also assume it changes data only while the clock is low, except for starts and stops, and only well after the falling edge. Under these conditions the synchronizer delay cannot make the block drive while the clock is high. The bench master holds each quarter bit for ten system clocks and moves data a full quarter bit after each falling edge. It builds the data line as a wired AND of its own drive and the block's enable.

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int ADDR_W = 15,
  parameter int RAM_AW = 10,
  parameter int PAGE_W = 6,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [PAGE_W-1:0] P_ONE = {{(PAGE_W-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {IDLE = 3'd0, DEV = 3'd1, AHI = 3'd2, ALO = 3'd3, WR = 3'd4, RD = 3'd5} st_t;

  st_t state;
  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic [3:0] bitcnt;
  logic ackph, rw, mack;
  logic [7:0] shreg, txsh, rd_q;
  logic [ADDR_W-1:0] addr;
  logic [7:0] mem [0:(1<<RAM_AW)-1];

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det = scl_s & scl_q & ~sda_q & sda_s;
  wire dev_hit = shreg[7:1] == {DEV_TYPE, strap_i};
  wire wr_go = scl_fall && state == WR && !ackph && bitcnt == 4'd8;
  wire [ADDR_W-1:0] page_next = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + P_ONE};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  always_ff @(posedge clk) begin
    if (wr_go) mem[addr[RAM_AW-1:0]] <= shreg;
    rd_q <= mem[addr[RAM_AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE; bitcnt <= '0; ackph <= 1'b0; sda_oe <= 1'b0;
      shreg <= '0; txsh <= '0; addr <= '0; rw <= 1'b0; mack <= 1'b0;
    end else if (start_det) begin
      state <= DEV; bitcnt <= '0; ackph <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      state <= IDLE; bitcnt <= '0; ackph <= 1'b0; sda_oe <= 1'b0;
    end else if (state != IDLE) begin
      if (scl_rise) begin
        if (ackph) mack <= ~sda_s;
        else if (bitcnt != 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (state != RD) shreg <= {shreg[6:0], sda_s};
        end
      end else if (scl_fall) begin
        if (ackph) begin
          ackph <= 1'b0; bitcnt <= '0; sda_oe <= 1'b0;
          case (state)
            DEV: if (rw) begin state <= RD; txsh <= rd_q; sda_oe <= ~rd_q[7]; end
                 else state <= AHI;
            AHI: state <= ALO;
            ALO: state <= WR;
            RD:  if (mack) begin txsh <= rd_q; sda_oe <= ~rd_q[7]; end
                 else state <= IDLE;
            default: ;
          endcase
        end else if (bitcnt == 4'd8) begin
          ackph <= 1'b1;
          case (state)
            DEV: if (dev_hit) begin sda_oe <= 1'b1; rw <= shreg[0]; end
                 else begin state <= IDLE; ackph <= 1'b0; end
            AHI: begin addr[ADDR_W-1:8] <= shreg[HI_W-1:0]; sda_oe <= 1'b1; end
            ALO: begin addr[7:0] <= shreg; sda_oe <= 1'b1; end
            WR:  begin addr <= page_next; sda_oe <= 1'b1; end
            RD:  begin addr <= addr + A_ONE; sda_oe <= 1'b0; end
            default: ;
          endcase
        end else if (state == RD && bitcnt != 4'd0) begin
          txsh <= {txsh[6:0], 1'b0};
          sda_oe <= ~txsh[6];
        end
      end
    end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [2:0]        st,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]        bitcnt,
  input logic              ackph,
  input logic              start_det,
  input logic              stop_det
);
  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_WR = 3'd4, S_RD = 3'd5;
  localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  p_drive_low_clk_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);

  p_start_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> st == S_DEV && bitcnt == 4'd0 && !sda_oe);

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> st == S_IDLE);

  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WR && $past(st) == S_WR |-> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RD && $past(st) == S_RD && addr != $past(addr) |-> addr == $past(addr) + A_ONE);

  p_ack_ninth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe && st != S_RD |-> ackph);

  p_bit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .st(state), .addr(addr),
  .bitcnt(bitcnt), .ackph(ackph), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/sim_twi_mem_slave.sv
`timescale 1ns/1ps
module sim_twi_mem_slave;
  localparam int Q = 80;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire sda_bus = sda_m & ~sda_oe;

  twi_mem_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
                    .strap_i(strap), .sda_oe(sda_oe));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0, bad12 = 0;
  bit done = 0;
  int exp_q[$];
  string req_q[$];
  int obs_v;
  event obs_ev;
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    if (sda_oe && !prev_oe && scl_m) bad12 <= bad12 + 1;
    prev_oe <= sda_oe;
  end

  initial begin
    int e;
    string r;
    forever begin
      @(obs_ev);
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected item: actual %0h expected none", obs_v);
      end else begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (obs_v != e) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", r, obs_v, e);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic expect_item(input int v, input string req);
    exp_q.push_back(v);
    req_q.push_back(req);
  endtask

  task automatic observe(input int v);
    obs_v = v;
    ->obs_ev;
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; #Q; scl_m = 1'b1; #Q; r = sda_bus; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic send(input logic [7:0] b, input int exp_ack, input string req);
    logic r;
    expect_item(exp_ack, req);
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    observe(int'(r));
  endtask

  task automatic recv(input logic [7:0] expv, input bit more, input string req);
    logic [7:0] v;
    logic r;
    expect_item(int'(expv), req);
    for (int i = 7; i >= 0; i--) bit_io(1'b1, v[i]);
    bit_io(!more, r);
    observe(int'(v));
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    bus_start;
    send(8'hAA, 0, "R3");
    send(hi, 0, req);
    send(lo, 0, req);
  endtask

  task automatic read_from(input logic [7:0] hi, input logic [7:0] lo, input string req);
    set_addr(hi, lo, req);
    bus_start;
    send(8'hAB, 0, req);
  endtask

  initial begin
    logic r;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #3 check(sda_oe == 1'b0, "R1", sda_oe, 0);

    // page of three bytes at 0x0240
    set_addr(8'h02, 8'h40, "R4");
    send(8'h11, 0, "R5"); send(8'h22, 0, "R5"); send(8'h33, 0, "R5");
    bus_stop;
    // bit 7 of the high byte ignored: lands at 0x0123
    set_addr(8'h81, 8'h23, "R4");
    send(8'h5C, 0, "R5"); send(8'hA5, 0, "R5");
    bus_stop;
    read_from(8'h01, 8'h23, "R8");
    recv(8'h5C, 0, "R4");
    bus_stop;
    bus_start; send(8'hAB, 0, "R7"); recv(8'hA5, 0, "R7"); bus_stop;
    read_from(8'h02, 8'h40, "R5");
    recv(8'h11, 1, "R5"); recv(8'h22, 1, "R5"); recv(8'h33, 0, "R5");
    bus_stop;

    // page roll-over on writes, none on reads
    set_addr(8'h00, 8'h80, "R4"); send(8'hEE, 0, "R6"); bus_stop;
    set_addr(8'h00, 8'h7E, "R4");
    send(8'h01, 0, "R6"); send(8'h02, 0, "R6"); send(8'h03, 0, "R6"); send(8'h04, 0, "R6");
    bus_stop;
    read_from(8'h00, 8'h40, "R6"); recv(8'h03, 1, "R6"); recv(8'h04, 0, "R6"); bus_stop;
    read_from(8'h00, 8'h7F, "R9"); recv(8'h02, 1, "R6"); recv(8'hEE, 0, "R9"); bus_stop;

    // full-space wrap on reads, then silence after master nack
    set_addr(8'h7F, 8'hFF, "R4"); send(8'hC3, 0, "R5"); bus_stop;
    set_addr(8'h00, 8'h00, "R4"); send(8'h3C, 0, "R5"); bus_stop;
    read_from(8'h7F, 8'hFF, "R9");
    recv(8'hC3, 1, "R9"); recv(8'h3C, 0, "R9"); recv(8'hFF, 0, "R10");
    bus_stop;

    // wrong strap: nothing acknowledged or stored
    bus_start;
    send(8'hA2, 1, "R3"); send(8'h01, 1, "R3"); send(8'h23, 1, "R3"); send(8'h00, 1, "R3");
    bus_stop;
    read_from(8'h01, 8'h23, "R3"); recv(8'h5C, 0, "R3"); bus_stop;

    // start inside a data byte
    set_addr(8'h01, 8'h23, "R11");
    for (int i = 0; i < 4; i++) bit_io(1'b0, r);
    bus_start;
    send(8'hAB, 0, "R11"); recv(8'h5C, 0, "R11");
    bus_stop;

    // bytes after a stop are ignored
    set_addr(8'h01, 8'h23, "R2");
    bus_stop;
    scl_m = 1'b0; #Q;
    send(8'hAA, 1, "R2"); send(8'h00, 1, "R2");
    bus_stop;
    bus_start; send(8'hAB, 0, "R2"); recv(8'h5C, 0, "R2"); bus_stop;

    #(4*Q);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    check(bad12 == 0, "R12", bad12, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule